// File: doc/BRIEF.md
# Interrupt Status Collector with Read-to-Clear Errors

This block gathers six event sources of a serial peripheral into one raw status vector, gates that vector with a per-source enable mask, and drives a single active-high interrupt line from the surviving bits. Two sources are level conditions: "transmit queue low" compares the transmit fill level against a threshold, and "receive queue high" compares the receive fill level against a threshold. These bits track the live comparison and never latch. The other four sources are error events: transmit overflow, receive underflow, receive overflow and bus contention by another master. Each of them latches on a one-cycle pulse and stays set until software clears it.

Software talks to the block through a small read port and a mask write strobe. Reading address 0, 1 or 2 returns the raw vector, the mask or the masked vector. Reading one of the clear addresses has a side effect: it clears the matching latched error, or every latched error at once, and returns that error's value from before the clear. Read data appears on the cycle after the read strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the raw, mask and masked vectors, `rd_data` and `irq` are all zero.
- R2: A one-cycle pulse on `evt_tx_ovf`, `evt_rx_udf`, `evt_rx_ovf` or `evt_mst` sets raw bit 1, 2, 3 or 5 on that clock edge, and the bit stays set while no clear read hits it.
- R3: A read of address 3 clears only raw bit 1, address 4 only bit 3, address 5 only bit 2, and address 6 only bit 5.
- R4: A read of address 7 clears raw bits 1, 2, 3 and 5 together.
- R5: A read of a clear address returns the cleared bit's pre-clear value in `rd_data[0]`, with all other bits zero. For address 7, bit 0 is the OR of the four latched bits.
- R6: When a source's event pulse and a clear read of that source fall on the same edge, the bit ends up set.
- R7: Raw bit 0 is 1 when `tx_level <= tx_thresh`, and raw bit 4 is 1 when `rx_level > rx_thresh`. Both are registered one edge after the inputs, and no clear read changes them.
- R8: The masked vector equals raw AND mask, where a mask bit of 1 enables that source. `mask_we` loads `mask_wdata`, and the masked vector reflects the new mask on the same edge.
- R9: `irq` is 1 exactly when the masked vector is nonzero, and it changes on the same edge as the masked vector.
- R10: A read of address 0, 1 or 2 returns the raw, mask or masked vector in bits [5:0], with the upper bits zero, on the cycle after `rd_en`. Addresses 8 to 15 return zero and change no state, and `rd_data` is zero in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_tx_ovf | input | 1 | Transmit overflow event pulse |
| evt_rx_udf | input | 1 | Receive underflow event pulse |
| evt_rx_ovf | input | 1 | Receive overflow event pulse |
| evt_mst | input | 1 | Multi-master contention event pulse |
| tx_level | input | LVL_W | Transmit queue fill level |
| tx_thresh | input | LVL_W | Transmit low threshold |
| rx_level | input | LVL_W | Receive queue fill level |
| rx_thresh | input | LVL_W | Receive high threshold |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | NSRC | New mask value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The contested case is an event pulse on the same edge as a read that clears that source. The bench raises `evt_tx_ovf` in the cycle it issues a read of address 3, and raises `evt_mst` in the cycle it issues a read of address 7. The read must return the old value, which is 0 and 1 in the two cases, and a raw read afterwards must show the bit set. A second pairing puts a clear-all read against live level conditions: the read must leave raw bits 0 and 4 untouched.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 6;
  localparam int RD_ADDR_W = 4;

  // field positions inside raw / mask / masked vectors
  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;
  localparam int B_MST = 5;

  // which positions hold latched error sources
  localparam logic [NSRC-1:0] LATCHED = 6'b101110;

  typedef enum logic [RD_ADDR_W-1:0] {
    A_RAW     = 4'd0,
    A_MASK    = 4'd1,
    A_STAT    = 4'd2,
    A_CLR_TXO = 4'd3,
    A_CLR_RXO = 4'd4,
    A_CLR_RXU = 4'd5,
    A_CLR_MST = 4'd6,
    A_CLR_ALL = 4'd7
  } rd_addr_e;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  // set has priority over a clearing read on the same edge
  always_comb nxt_o = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int LVL_W = 5,
  parameter bit ABOVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             nxt_o,
  output logic             q_o
);
  generate
    if (ABOVE) begin : g_above
      always_comb nxt_o = (level > thresh);
    end else begin : g_at_or_below
      always_comb nxt_o = (level <= thresh);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  input  logic [NSRC-1:0]      raw_q,
  input  logic [NSRC-1:0]      mask_q,
  input  logic [NSRC-1:0]      masked_q,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int PAD_W = DATA_W - NSRC;

  logic [NSRC-1:0] sel_vec;

  always_comb begin
    sel_vec = '0;
    case (rd_addr)
      A_RAW:     sel_vec = raw_q;
      A_MASK:    sel_vec = mask_q;
      A_STAT:    sel_vec = masked_q;
      A_CLR_TXO: sel_vec[0] = raw_q[B_TXO];
      A_CLR_RXO: sel_vec[0] = raw_q[B_RXO];
      A_CLR_RXU: sel_vec[0] = raw_q[B_RXU];
      A_CLR_MST: sel_vec[0] = raw_q[B_MST];
      A_CLR_ALL: sel_vec[0] = |(raw_q & LATCHED);
      default:   sel_vec = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{PAD_W{1'b0}}, sel_vec};
    else            rd_data <= '0;
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
  // R5
  clr_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr >= A_CLR_TXO && rd_addr <= A_CLR_ALL)
      |=> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 evt_tx_ovf,
  input  logic                 evt_rx_udf,
  input  logic                 evt_rx_ovf,
  input  logic                 evt_mst,
  input  logic [LVL_W-1:0]     tx_level,
  input  logic [LVL_W-1:0]     tx_thresh,
  input  logic [LVL_W-1:0]     rx_level,
  input  logic [LVL_W-1:0]     rx_thresh,
  input  logic                 mask_we,
  input  logic [NSRC-1:0]      mask_wdata,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq
);
  logic [NSRC-1:0] raw_q, raw_nxt;
  logic [NSRC-1:0] mask_q, mask_nxt;
  logic [NSRC-1:0] masked_q;
  logic [NSRC-1:0] clr_vec;
  logic            clr_all;

  assign clr_all = rd_en && (rd_addr == A_CLR_ALL);

  always_comb begin
    clr_vec        = '0;
    clr_vec[B_TXO] = clr_all || (rd_en && rd_addr == A_CLR_TXO);
    clr_vec[B_RXO] = clr_all || (rd_en && rd_addr == A_CLR_RXO);
    clr_vec[B_RXU] = clr_all || (rd_en && rd_addr == A_CLR_RXU);
    clr_vec[B_MST] = clr_all || (rd_en && rd_addr == A_CLR_MST);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LATCHED[i]) begin : g_latch
      logic set_s;
      case (i)
        B_TXO:   begin : g_s assign set_s = evt_tx_ovf; end
        B_RXU:   begin : g_s assign set_s = evt_rx_udf; end
        B_RXO:   begin : g_s assign set_s = evt_rx_ovf; end
        default: begin : g_s assign set_s = evt_mst;    end
      endcase
      irq_evt_latch u_latch (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_s),
        .clr_i (clr_vec[i]),
        .nxt_o (raw_nxt[i]),
        .q_o   (raw_q[i])
      );
    end else if (i == B_TXE) begin : g_tx_low
      irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b0)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .level  (tx_level),
        .thresh (tx_thresh),
        .nxt_o  (raw_nxt[i]),
        .q_o    (raw_q[i])
      );
    end else begin : g_rx_high
      irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b1)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .level  (rx_level),
        .thresh (rx_thresh),
        .nxt_o  (raw_nxt[i]),
        .q_o    (raw_q[i])
      );
    end
  end

  assign mask_nxt = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      masked_q <= '0;
      irq      <= 1'b0;
    end else begin
      mask_q   <= mask_nxt;
      masked_q <= raw_nxt & mask_nxt;
      irq      <= |(raw_nxt & mask_nxt);
    end
  end

  irq_rd_port #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .raw_q    (raw_q),
    .mask_q   (mask_q),
    .masked_q (masked_q),
    .rd_data  (rd_data)
  );

  // R8
  masked_and_chk: assert property (@(posedge clk) disable iff (rst)
    masked_q == (raw_q & mask_q));
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (masked_q != '0));
  // R7
  level_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_all && (tx_level <= tx_thresh)) |=> raw_q[B_TXE]);
  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr > A_CLR_ALL && !evt_tx_ovf && !evt_rx_udf
     && !evt_rx_ovf && !evt_mst)
      |=> ((raw_q & LATCHED) == ($past(raw_q) & LATCHED)));
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  localparam int CLK_P = 10;
  localparam int LVL_W = 5;
  localparam int DW    = 32;

  logic clk = 0, rst = 1;
  logic evt_tx_ovf = 0, evt_rx_udf = 0, evt_rx_ovf = 0, evt_mst = 0;
  logic [LVL_W-1:0] tx_level = 5, tx_thresh = 2, rx_level = 0, rx_thresh = 3;
  logic mask_we = 0;
  logic [5:0] mask_wdata = 0;
  logic rd_en = 0;
  logic [3:0] rd_addr = 0;
  logic [DW-1:0] rd_data;
  logic irq;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_status_ctrl #(.LVL_W(LVL_W), .DATA_W(DW)) i_irq_status_ctrl (
    .clk(clk), .rst(rst),
    .evt_tx_ovf(evt_tx_ovf), .evt_rx_udf(evt_rx_udf),
    .evt_rx_ovf(evt_rx_ovf), .evt_mst(evt_mst),
    .tx_level(tx_level), .tx_thresh(tx_thresh),
    .rx_level(rx_level), .rx_thresh(rx_thresh),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: issue a read and queue its expected data
  task automatic rd(logic [3:0] a, logic [DW-1:0] exp, string tag);
    rd_en = 1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0; rd_addr = 0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wmask(logic [5:0] m);
    mask_we = 1; mask_wdata = m; @(negedge clk); mask_we = 0;
  endtask

  // monitor: compare read results as they appear
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        #(CLK_P/4);
        if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  bit done = 0;
  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq}, 0);
    chk("R1 rd_data in reset", rd_data, 0);
    rst = 0;
    tick();
    rd(0, 0, "R1 raw after reset");
    rd(1, 0, "R1 mask after reset");
    rd(2, 0, "R1 masked after reset");

    // R2 latch and hold
    evt_tx_ovf = 1; tick(); evt_tx_ovf = 0;
    rd(0, 32'h02, "R2 tx overflow latched");
    evt_mst = 1; tick(); evt_mst = 0;
    repeat (4) tick();
    rd(0, 32'h22, "R2 contention latched and held");

    // R8 R9 mask gating
    wmask(6'h02);
    chk("R9 irq with tx ovf enabled", {31'b0, irq}, 1);
    rd(2, 32'h02, "R8 masked tx ovf");
    rd(1, 32'h02, "R10 mask readback");
    wmask(6'h20);
    rd(2, 32'h20, "R8 masked contention");
    wmask(6'h01);
    chk("R9 irq low when nothing enabled", {31'b0, irq}, 0);
    rd(2, 32'h00, "R8 masked none");

    // R3 R5 individual clears
    rd(3, 1, "R5 clear tx ovf returns old 1");
    rd(0, 32'h20, "R3 only bit1 cleared");
    rd(3, 0, "R5 clear tx ovf returns 0");
    evt_rx_ovf = 1; evt_rx_udf = 1; tick(); evt_rx_ovf = 0; evt_rx_udf = 0;
    rd(0, 32'h2C, "R2 rx errors latched");
    rd(5, 1, "R5 clear rx udf old value");
    rd(0, 32'h28, "R3 only bit2 cleared");
    rd(4, 1, "R5 clear rx ovf old value");
    rd(0, 32'h20, "R3 only bit3 cleared");
    rd(6, 1, "R5 clear contention old value");
    rd(0, 32'h00, "R3 only bit5 cleared");

    // R4 clear all
    evt_tx_ovf = 1; evt_rx_udf = 1; evt_rx_ovf = 1; evt_mst = 1; tick();
    evt_tx_ovf = 0; evt_rx_udf = 0; evt_rx_ovf = 0; evt_mst = 0;
    rd(0, 32'h2E, "R2 all errors latched");
    rd(7, 1, "R5 clear all returns 1");
    rd(0, 32'h00, "R4 all latched cleared");
    rd(7, 0, "R5 clear all returns 0");

    // R6 event vs clear on same edge
    evt_tx_ovf = 1; rd(3, 0, "R6 clear read old value 0"); evt_tx_ovf = 0;
    rd(0, 32'h02, "R6 tx ovf set despite clear");
    evt_mst = 1; rd(7, 1, "R6 clear all old value 1"); evt_mst = 0;
    rd(0, 32'h20, "R6 contention kept, tx ovf cleared");
    rd(6, 1, "R3 clear contention");

    // R7 level sources
    tx_level = 2; tx_thresh = 2; tick();
    rd(0, 32'h01, "R7 tx at threshold");
    rx_level = 4; tick();
    rd(0, 32'h11, "R7 rx above threshold");
    wmask(6'h11);
    chk("R9 irq from level sources", {31'b0, irq}, 1);
    rd(2, 32'h11, "R8 masked level bits");
    rd(7, 0, "R7 clear all with only levels");
    rd(0, 32'h11, "R7 levels survive clear");
    rx_level = 3; tick();
    rd(0, 32'h01, "R7 rx equal threshold not above");
    tx_level = 3; tick();
    chk("R9 irq drops with levels", {31'b0, irq}, 0);
    rd(0, 32'h00, "R7 tx above threshold clears bit0");

    // R10 unmapped addresses
    rd(9, 0, "R10 addr 9 reads zero");
    rd(15, 0, "R10 addr 15 reads zero");
    evt_rx_ovf = 1; tick(); evt_rx_ovf = 0;
    rd(9, 0, "R10 addr 9 no side effect");
    rd(0, 32'h08, "R10 rx ovf kept after unmapped read");
    rd(4, 1, "R3 clear rx ovf");
    tick();
    chk("R10 rd_data idle zero", rd_data, 0);

    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule